// File: doc/BRIEF.md
# RTC Rate Trim Pulse Sequencer

This block fine-tunes the rate of a real-time clock. It divides the oscillator clock into a one-second tick. At scheduled instants it lengthens or shortens selected seconds by whole oscillator cycles, so that the mean rate drifts toward the true second. An 8-bit trim setting chooses one of two schedules and gives a signed number of correction pulses. A positive count shortens the affected seconds and a negative count lengthens them.

The slow schedule starts a burst once every long period, 120 minutes by default. It then applies one pulse per minute until the count is used up. The fast schedule starts a burst once every short period, four minutes by default. It applies one pulse per second for seconds 0 to 58, and puts everything that remains into second 59 of that minute. The block counts its own seconds and minutes to place the bursts. A busy flag shows while a burst is running. The divisor and all interval lengths are parameters, so short counts can be used in simulation.

Top module: `rtc_trim_seq`

## Requirements
- R1: With no correction active, `sec_tick` is high for exactly one `clk_osc` cycle in every `TICK_DIV` cycles.
- R2: `trim_cfg[7]` selects the schedule (0 = slow, 1 = fast). `trim_cfg[6:0]` is a two's-complement pulse count from -64 to +63. The schedule and count are sampled at a trigger instant.
- R3: On the slow schedule, a burst triggers at the tick that begins second 0 of every `SLOW_PERIOD_MIN`-th minute. One pulse is applied in second 0 of each minute, starting with the trigger minute, until the count's magnitude is used up.
- R4: On the fast schedule, a burst triggers at the tick that begins second 0 of every `FAST_PERIOD_MIN`-th minute. One pulse is applied in each of seconds 0 to 58 while pulses remain.
- R5: On the fast schedule, second 59 of the burst minute takes all pulses still remaining (magnitude minus 59 when the magnitude is 60 or more). Each pulse changes that second by one distinct cycle.
- R6: A second that carries k pulses lasts `TICK_DIV - k` cycles for a positive count and `TICK_DIV + k` cycles for a negative count.
- R7: `trim_busy` rises in the cycle after the triggering tick. It falls in the cycle after the tick that ends the second carrying the last pulse.
- R8: A change of `trim_cfg` from one cycle to the next aborts the running burst. `trim_busy` is low in the following cycle, and no second after the one in progress is altered. The new setting is used at the next trigger instant.
- R9: While `rst_n` is low, both outputs are low. After `rst_n` rises, the first `sec_tick` is seen after the `TICK_DIV+1`-th rising clock edge, because two edges are spent synchronizing the reset release.
- R10: A pulse count of zero never starts a burst and never alters a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trim_cfg | input | 8 | Bit 7 schedule select, bits 6:0 signed pulse count |
| sec_tick | output | 1 | One-cycle strobe in the last cycle of each second |
| trim_busy | output | 1 | High while a correction burst is in progress |

## Verification
The hardest cases to reach are the overflow second 59 of a fast burst with a magnitude above 60, and an abort that lands in the middle of a burst at a known second. Both need whole minutes of ticks before the condition can occur. The bench shrinks the divisor and the slow period so that several bursts fit in a short run. It waits for the busy flag to rise, counts twenty ticks, and then changes the setting exactly on a second boundary. The per-cycle reference model and histograms of the measured second lengths then confirm how many seconds were shortened or lengthened, and by how much.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  typedef enum logic {
    TRIM_SLOW = 1'b0,
    TRIM_FAST = 1'b1
  } trim_mode_e;

  localparam int TRIM_MAG_MAX = 64;

  // magnitude of a 7-bit two's-complement count (0..64)
  function automatic logic [6:0] trim_mag(input logic [6:0] cnt);
    return cnt[6] ? (~cnt + 7'd1) : cnt;
  endfunction

  // largest number of pulses a single second can carry
  function automatic int trim_kmax(input int secs_per_min);
    return (TRIM_MAG_MAX > secs_per_min - 1) ? (TRIM_MAG_MAX - (secs_per_min - 1)) : 1;
  endfunction

endpackage

// File: rtl/rtc_trim_presc.sv
module rtc_trim_presc #(
  parameter int TICK_DIV = 32768,
  parameter int KW       = 3,
  parameter int KMAX     = 5
) (
  input  logic          clk_osc,
  input  logic          rst_i_n,
  input  logic [KW-1:0] pulse_k,
  input  logic          pulse_neg,
  output logic          tick
);

  localparam int LMAX = TICK_DIV + KMAX;
  localparam int CW   = $clog2(LMAX + 1);

  logic [CW-1:0] pre_q, pre_d, last_idx;

  always_comb begin
    if (pulse_neg) last_idx = CW'(TICK_DIV - 1) + CW'(pulse_k);
    else           last_idx = CW'(TICK_DIV - 1) - CW'(pulse_k);
    tick  = (pre_q == last_idx);
    pre_d = tick ? '0 : pre_q + CW'(1);
  end

  always_ff @(posedge clk_osc or negedge rst_i_n) begin
    if (!rst_i_n) pre_q <= '0;
    else          pre_q <= pre_d;
  end

endmodule

// File: rtl/rtc_trim_timebase.sv
module rtc_trim_timebase #(
  parameter int SECS_PER_MIN    = 60,
  parameter int SLOW_PERIOD_MIN = 120,
  parameter int FAST_PERIOD_MIN = 4,
  localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1
) (
  input  logic          clk_osc,
  input  logic          rst_i_n,
  input  logic          tick,
  output logic [SW-1:0] sec_nxt,
  output logic          slow_hit,
  output logic          fast_hit
);

  localparam int MSW = (SLOW_PERIOD_MIN > 1) ? $clog2(SLOW_PERIOD_MIN) : 1;
  localparam int MFW = (FAST_PERIOD_MIN > 1) ? $clog2(FAST_PERIOD_MIN) : 1;

  logic [SW-1:0]  sec_q;
  logic [MSW-1:0] mins_q, mins_d;
  logic [MFW-1:0] minf_q, minf_d;
  logic           wrap;

  always_comb begin
    wrap    = (sec_q == SW'(SECS_PER_MIN - 1));
    sec_nxt = wrap ? '0 : sec_q + SW'(1);
    mins_d  = mins_q;
    minf_d  = minf_q;
    if (wrap) begin
      mins_d = (mins_q == MSW'(SLOW_PERIOD_MIN - 1)) ? '0 : mins_q + MSW'(1);
      minf_d = (minf_q == MFW'(FAST_PERIOD_MIN - 1)) ? '0 : minf_q + MFW'(1);
    end
    slow_hit = wrap && (mins_d == '0);
    fast_hit = wrap && (minf_d == '0);
  end

  always_ff @(posedge clk_osc or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sec_q  <= '0;
      mins_q <= '0;
      minf_q <= '0;
    end else if (tick) begin
      sec_q  <= sec_nxt;
      mins_q <= mins_d;
      minf_q <= minf_d;
    end
  end

endmodule

// File: rtl/rtc_trim_burst.sv
module rtc_trim_burst
  import rtc_trim_pkg::*;
#(
  parameter int SECS_PER_MIN = 60,
  parameter int KW           = 3,
  localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1
) (
  input  logic          clk_osc,
  input  logic          rst_i_n,
  input  logic          tick,
  input  logic          abort,
  input  logic [7:0]    cfg,
  input  logic [SW-1:0] sec_nxt,
  input  logic          slow_hit,
  input  logic          fast_hit,
  output logic [KW-1:0] pulse_k,
  output logic          pulse_neg,
  output logic          busy
);

  trim_mode_e    mode_q, mode_d, mode_l, cfg_mode;
  logic [6:0]    rem_q, rem_d, rem_l, cfg_mag;
  logic          act_q, act_d, act_l;
  logic          neg_q, neg_d, neg_l;
  logic [KW-1:0] k_q, k_d, k_l;
  logic          trig;

  always_comb begin
    cfg_mode = trim_mode_e'(cfg[7]);
    cfg_mag  = trim_mag(cfg[6:0]);
    trig     = tick && (cfg_mag != '0) &&
               ((cfg_mode == TRIM_FAST) ? fast_hit : slow_hit);

    rem_l  = rem_q;
    act_l  = act_q;
    mode_l = mode_q;
    neg_l  = neg_q;
    if (trig) begin
      rem_l  = cfg_mag;
      act_l  = 1'b1;
      mode_l = cfg_mode;
      neg_l  = cfg[6];
    end else if (act_q && (rem_q == '0)) begin
      act_l = 1'b0;
    end

    k_l = '0;
    if (act_l && (rem_l != '0)) begin
      if (mode_l == TRIM_FAST)
        k_l = (sec_nxt == SW'(SECS_PER_MIN - 1)) ? rem_l[KW-1:0] : KW'(1);
      else if (sec_nxt == '0)
        k_l = KW'(1);
    end

    rem_d  = rem_q;
    act_d  = act_q;
    mode_d = mode_q;
    neg_d  = neg_q;
    k_d    = k_q;
    if (abort) begin
      rem_d = '0;
      act_d = 1'b0;
      if (tick) k_d = '0;
    end else if (tick) begin
      rem_d  = rem_l - 7'(k_l);
      act_d  = act_l;
      mode_d = mode_l;
      neg_d  = neg_l;
      k_d    = k_l;
    end
  end

  always_ff @(posedge clk_osc or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rem_q  <= '0;
      act_q  <= 1'b0;
      mode_q <= TRIM_SLOW;
      neg_q  <= 1'b0;
      k_q    <= '0;
    end else begin
      rem_q  <= rem_d;
      act_q  <= act_d;
      mode_q <= mode_d;
      neg_q  <= neg_d;
      k_q    <= k_d;
    end
  end

  assign pulse_k   = k_q;
  assign pulse_neg = neg_q;
  assign busy      = act_q;

endmodule

// File: rtl/rtc_trim_seq.sv
module rtc_trim_seq
  import rtc_trim_pkg::*;
#(
  parameter int TICK_DIV        = 32768,
  parameter int SECS_PER_MIN    = 60,
  parameter int SLOW_PERIOD_MIN = 120,
  parameter int FAST_PERIOD_MIN = 4
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [7:0] trim_cfg,
  output logic       sec_tick,
  output logic       trim_busy
);

  localparam int KMAX = trim_kmax(SECS_PER_MIN);
  localparam int KW   = (KMAX > 1) ? $clog2(KMAX + 1) : 1;
  localparam int SW   = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic [7:0]    cfg_q;
  logic          cfg_chg;
  logic [KW-1:0] pulse_k;
  logic          pulse_neg;
  logic [SW-1:0] sec_nxt;
  logic          slow_hit, fast_hit;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_ff @(posedge clk_osc or negedge rst_i_n) begin
    if (!rst_i_n) cfg_q <= '0;
    else          cfg_q <= trim_cfg;
  end
  assign cfg_chg = (trim_cfg != cfg_q);

  rtc_trim_presc #(.TICK_DIV(TICK_DIV), .KW(KW), .KMAX(KMAX)) presc_i (
    .clk_osc   (clk_osc),
    .rst_i_n   (rst_i_n),
    .pulse_k   (pulse_k),
    .pulse_neg (pulse_neg),
    .tick      (sec_tick)
  );

  rtc_trim_timebase #(
    .SECS_PER_MIN    (SECS_PER_MIN),
    .SLOW_PERIOD_MIN (SLOW_PERIOD_MIN),
    .FAST_PERIOD_MIN (FAST_PERIOD_MIN)
  ) tbase_i (
    .clk_osc  (clk_osc),
    .rst_i_n  (rst_i_n),
    .tick     (sec_tick),
    .sec_nxt  (sec_nxt),
    .slow_hit (slow_hit),
    .fast_hit (fast_hit)
  );

  rtc_trim_burst #(.SECS_PER_MIN(SECS_PER_MIN), .KW(KW)) burst_i (
    .clk_osc   (clk_osc),
    .rst_i_n   (rst_i_n),
    .tick      (sec_tick),
    .abort     (cfg_chg),
    .cfg       (trim_cfg),
    .sec_nxt   (sec_nxt),
    .slow_hit  (slow_hit),
    .fast_hit  (fast_hit),
    .pulse_k   (pulse_k),
    .pulse_neg (pulse_neg),
    .busy      (trim_busy)
  );

endmodule

// File: rtl/rtc_trim_seq_chk.sv
module rtc_trim_seq_chk
  import rtc_trim_pkg::*;
#(
  parameter int TICK_DIV     = 32768,
  parameter int SECS_PER_MIN = 60
) (
  input logic       clk_osc,
  input logic       rst_n,
  input logic [7:0] trim_cfg,
  input logic       sec_tick,
  input logic       trim_busy
);

  localparam int KMAX = trim_kmax(SECS_PER_MIN);

  logic [7:0] cfg_prev;
  logic       prev_ok, chg_q, seen_q;
  int         gap_q;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      cfg_prev <= '0;
      prev_ok  <= 1'b0;
      chg_q    <= 1'b0;
      seen_q   <= 1'b0;
      gap_q    <= 0;
    end else begin
      cfg_prev <= trim_cfg;
      prev_ok  <= 1'b1;
      chg_q    <= prev_ok && (trim_cfg != cfg_prev);
      seen_q   <= seen_q | sec_tick;
      gap_q    <= sec_tick ? 0 : gap_q + 1;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R1

  AST_SEC_LEN_BOUND: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (seen_q && sec_tick) |-> ((gap_q + 1 >= TICK_DIV - KMAX) && (gap_q + 1 <= TICK_DIV + KMAX))); // R6

  AST_BUSY_RISE_ON_TICK: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(trim_busy) |-> $past(sec_tick)); // R7

  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(trim_busy) |-> ($past(sec_tick) || chg_q)); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (prev_ok && (trim_cfg != cfg_prev)) |=> !trim_busy); // R8

  AST_ZERO_NO_BURST: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ((trim_cfg[6:0] == 7'd0) && !trim_busy) |=> !trim_busy); // R10

endmodule

bind rtc_trim_seq rtc_trim_seq_chk #(
  .TICK_DIV     (TICK_DIV),
  .SECS_PER_MIN (SECS_PER_MIN)
) chk_i (
  .clk_osc   (clk_osc),
  .rst_n     (rst_n),
  .trim_cfg  (trim_cfg),
  .sec_tick  (sec_tick),
  .trim_busy (trim_busy)
);

// File: tb/rtc_trim_seq_tb_top.sv
`timescale 1ns/1ps
module rtc_trim_seq_tb_top;

  localparam int DIV  = 16;
  localparam int SPM  = 60;
  localparam int SLOW = 8;
  localparam int FAST = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] trim_cfg;
  logic       sec_tick, trim_busy;

  always #2.5 clk = ~clk;

  rtc_trim_seq #(
    .TICK_DIV(DIV), .SECS_PER_MIN(SPM), .SLOW_PERIOD_MIN(SLOW), .FAST_PERIOD_MIN(FAST)
  ) dut_i (
    .clk_osc(clk), .rst_n(rst_n), .trim_cfg(trim_cfg),
    .sec_tick(sec_tick), .trim_busy(trim_busy)
  );

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R9";

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rs, m_pre, m_sec, m_ms, m_mf, m_k, m_rem;
  bit m_act, m_neg, m_mode;
  logic [7:0] m_off;

  task automatic m_clear();
    m_pre = 0; m_sec = 0; m_ms = 0; m_mf = 0; m_k = 0; m_rem = 0;
    m_act = 0; m_neg = 0; m_mode = 0; m_off = 8'h00;
  endtask

  function automatic int m_len();
    return m_neg ? DIV + m_k : DIV - m_k;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0;
      m_clear();
    end else begin
      int  was;
      bit  tk, chg, wrap, hit;
      int  mag;
      was  = m_rs;
      m_rs = (m_rs < 2) ? m_rs + 1 : 2;
      if (was < 2) m_clear();
      else begin
        tk  = (m_pre == m_len() - 1);
        chg = (trim_cfg != m_off);
        m_off = trim_cfg;
        if (tk) begin
          m_pre = 0;
          wrap  = (m_sec == SPM - 1);
          m_sec = wrap ? 0 : m_sec + 1;
          if (wrap) begin
            m_ms = (m_ms + 1) % SLOW;
            m_mf = (m_mf + 1) % FAST;
          end
          mag = int'($signed(trim_cfg[6:0]));
          hit = wrap && (mag != 0) && (trim_cfg[7] ? (m_mf == 0) : (m_ms == 0));
          if (chg) begin
            m_act = 0; m_rem = 0; m_k = 0;
          end else begin
            if (hit) begin
              m_act = 1; m_rem = (mag < 0) ? -mag : mag;
              m_mode = trim_cfg[7]; m_neg = (mag < 0);
            end else if (m_act && m_rem == 0) m_act = 0;
            m_k = 0;
            if (m_act && m_rem > 0) begin
              if (m_mode) m_k = (m_sec == SPM - 1) ? m_rem : 1;
              else if (m_sec == 0) m_k = 1;
            end
            m_rem -= m_k;
          end
        end else begin
          m_pre++;
          if (chg) begin m_act = 0; m_rem = 0; end
        end
      end
    end
  end

  // per-cycle comparison and second-length histogram
  int hist[int];
  int gap = 0;
  bit seen = 0;

  function automatic int hget(input int k);
    return hist.exists(k) ? hist[k] : 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " tick"}, int'(sec_tick), int'(m_rs == 2 && m_pre == m_len() - 1));
      check({cur_req, " busy"}, int'(trim_busy), int'(m_act));
      if (sec_tick) begin
        if (seen) hist[gap + 1] = hget(gap + 1) + 1;
        seen = 1; gap = 0;
      end else gap++;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t;
    rst_n = 1'b0; trim_cfg = 8'h00;
    run(5);
    check("R9 reset tick", int'(sec_tick), 0);
    check("R9 reset busy", int'(trim_busy), 0);
    rst_n = 1'b1;
    t = 0;
    while (!sec_tick && t < 100) begin @(negedge clk); t++; end
    check("R9 first tick edge", t, DIV + 1);

    cur_req = "R1/R10";                 // zero count across a fast trigger point
    run(3880);
    check("R1 only nominal seconds", hist.size(), 1);
    check("R10 nominal count", hget(DIV) > 200 ? 1 : 0, 1);

    cur_req = "R4/R5";                  // fast schedule, +63 -> bit7=1, bits6:0=0111111
    trim_cfg = 8'hBF; hist.delete();
    run(6660);
    check("R4 seconds shortened by one", hget(DIV - 1), 59);
    check("R5 second 59 takes 4 pulses", hget(DIV - 4), 1);
    check("R6 shape of +63 burst", hist.size(), 3);

    cur_req = "R6";                     // fast schedule, -64 -> 8'hC0
    trim_cfg = 8'hC0; hist.delete();
    run(3840);
    check("R6 seconds lengthened by one", hget(DIV + 1), 59);
    check("R5 second 59 lengthened by 5", hget(DIV + 5), 1);

    cur_req = "R3";                     // slow schedule, -3 -> bit7=0, bits6:0=1111101
    trim_cfg = 8'h7D; hist.delete();
    run(4320);
    check("R3 one pulse per minute", hget(DIV + 1), 3);
    check("R2 slow schedule not per-second", hist.size(), 2);

    cur_req = "R8";                     // fast +40 then abort after 20 seconds
    trim_cfg = 8'hA8; hist.delete();
    t = 0;
    while (!trim_busy && t < 4000) begin @(negedge clk); t++; end
    check("R7 busy rises at trigger", int'(trim_busy), 1);
    t = 0;
    while (t < 20) begin @(negedge clk); if (sec_tick) t++; end
    trim_cfg = 8'h00;
    @(negedge clk);
    check("R8 busy dropped after abort", int'(trim_busy), 0);
    run(4800);
    check("R8 pulses stop at abort", hget(DIV - 1), 20);
    check("R8 nothing after abort", hist.size(), 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule